// File: doc/BRIEF.md
# Attribute-Steered Store Buffer

This block sits between a processor's data port and a slower memory write port. Every store arrives with its address, its data, the effective bufferable (B) and cacheable (C) attributes of its region, a cache-hit flag and a swap flag. The block decides, per access, whether the store enters a 16-entry first-in first-out queue, goes to memory directly while the processor waits, or is absorbed by the cache and never reaches memory.

Reads to non-cacheable space, and line fills requested by the cache side, are held back until every queued store has reached memory. The cache arrays and the line-fill engine are outside the block. A single request input and a grant output stand in for the fill engine.

The processor side is a request/stall pair: a request is taken at the rising edge where `cpu_req` is high and `cpu_stall` is low. The memory side is a valid/ready pair, and a word moves at an edge where both are high.

Top module: `wbuf_policy_top`

## Requirements
- R1: After reset the queue is empty. `mem_valid` and `dirty_mark` are low, and `cpu_stall` is low while no request is present.
- R2: A store with B=0, C=0 is presented on the memory port, with its own address and data, only once the queue is empty. `cpu_stall` stays high until the memory accepts the word, and it drops in the same cycle that `mem_ready` is high.
- R3: A store with B=0, C=1 is queued whether or not it hits the cache. It is taken without a stall while the queue has room, and it raises no dirty mark.
- R4: A store with B=1, C=0 is queued. A swap with C=0 is never queued: it waits behind the queued stores and is then handled as a direct store (R2).
- R5: A store with B=1, C=1 that hits the cache is not queued and never reaches memory. `dirty_mark` is high for exactly the one cycle after its acceptance edge. A store with B=1, C=1 that misses is queued.
- R6: A read with C=0 is stalled while the queue holds any entry. A read with C=1 is taken without a stall.
- R7: `fill_go` is high only while `fill_req` is high and the queue is empty.
- R8: The queue holds 16 entries. A queued store arriving at a full queue stalls until an entry leaves.
- R9: Queued stores leave in arrival order. While `mem_valid` is high and `mem_ready` is low, the presented address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until taken |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_swap | input | 1 | Access is the store half of a swap |
| cpu_addr | input | 32 | Access address |
| cpu_wdata | input | 32 | Store data |
| cpu_bufable | input | 1 | Effective bufferable attribute (B) |
| cpu_cachable | input | 1 | Effective cacheable attribute (C) |
| cpu_hit | input | 1 | Access hits the data cache |
| cpu_stall | output | 1 | Request cannot be taken this cycle |
| fill_req | input | 1 | Cache side wants to start a line fill |
| fill_go | output | 1 | Line fill may start |
| mem_valid | output | 1 | Memory write word is presented |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory takes the word at this edge |
| dirty_mark | output | 1 | One-cycle pulse for an absorbed write-back hit |

## Verification
The stall, the memory-port outputs and `fill_go` are combinational from the inputs and the queue state. The bench therefore drives each stimulus at a falling edge and samples these outputs half a cycle later, in the same cycle. A queued store appears at the memory port in the cycle after its acceptance edge, and a pop shows the next entry in the cycle after the edge where ready was high. `dirty_mark` is a registered pulse: it is checked in the cycle right after the acceptance edge, and again one cycle later to confirm that it has dropped.

// File: rtl/wbuf_pkg.sv
// Shared types for the store buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package wbuf_pkg;
    // Outcome chosen for the access currently on the processor port.
    typedef enum logic [2:0] {
        ACT_IDLE,        // no request
        ACT_DIRECT,      // unbuffered store: wait for empty queue and memory
        ACT_QUEUE,       // store enters the queue
        ACT_ABSORB,      // write-back hit: cache keeps it, mark dirty
        ACT_READ_DRAIN,  // non-cacheable read: wait for empty queue
        ACT_READ_FREE    // cacheable read: no interaction with the queue
    } wb_act_e;
endpackage

// File: rtl/wbuf_classify.sv
// Maps an access and its region attributes to one queue action.
// Assumes: attributes are already the effective ones (region bits
// combined with unit enables) and are held stable with the request.
module wbuf_classify
    import wbuf_pkg::*;
(
    input  logic    req,
    input  logic    we,
    input  logic    swap,
    input  logic    bufable,
    input  logic    cachable,
    input  logic    hit,
    output wb_act_e act
);
    // Decode the action from access kind and B/C/hit.
    always_comb begin
        act = ACT_IDLE;
        if (req) begin
            if (!we) begin
                act = cachable ? ACT_READ_FREE : ACT_READ_DRAIN;
            end else if (swap && !cachable) begin
                act = ACT_DIRECT;
            end else begin
                unique case ({bufable, cachable})
                    2'b00:   act = ACT_DIRECT;
                    2'b01:   act = ACT_QUEUE;
                    2'b10:   act = ACT_QUEUE;
                    default: act = hit ? ACT_ABSORB : ACT_QUEUE;
                endcase
            end
        end
    end
endmodule

// File: rtl/wbuf_fifo.sv
// Address/data queue, first in first out, with an occupancy count.
// Assumes: the caller never pushes when full nor pops when empty;
// both are checked below.
module wbuf_fifo #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Store the pushed word at the write slot.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Present the oldest entry and the fill flags.
    always_comb begin
        head_addr = addr_q[rd_ptr];
        head_data = data_q[rd_ptr];
        empty     = (count == '0);
        full      = (count == CAP);
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CAP) |-> !push);
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !pop);
endmodule

// File: rtl/wbuf_mem_port.sv
// Drives the memory write port from the queue head or, when the queue
// is empty, straight from a direct store on the processor port.
// Assumes: a direct store is only offered while it is the current request.
module wbuf_mem_port #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_empty,
    input  logic [AW-1:0] q_addr,
    input  logic [DW-1:0] q_data,
    input  logic          direct_req,
    input  logic [AW-1:0] direct_addr,
    input  logic [DW-1:0] direct_data,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          q_pop
);
    // Queue has priority; direct store only once the queue is empty.
    always_comb begin
        mem_valid = !q_empty || direct_req;
        mem_addr  = q_empty ? direct_addr : q_addr;
        mem_data  = q_empty ? direct_data : q_data;
        q_pop     = !q_empty && mem_ready;
    end

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !q_empty)
            |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
endmodule

// File: rtl/wbuf_policy_top.sv
// Store buffer steered by region attributes: queues, bypasses or absorbs
// each store, and holds non-cacheable reads and line fills until drained.
// Assumes: the processor holds a request and its fields until taken.
module wbuf_policy_top
    import wbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_swap,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_bufable,
    input  logic          cpu_cachable,
    input  logic          cpu_hit,
    output logic          cpu_stall,
    input  logic          fill_req,
    output logic          fill_go,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ready,
    output logic          dirty_mark
);
    wb_act_e       act;
    logic          q_empty, q_full, q_pop, push, accept;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_data;

    wbuf_classify u_classify (
        .req      (cpu_req),
        .we       (cpu_we),
        .swap     (cpu_swap),
        .bufable  (cpu_bufable),
        .cachable (cpu_cachable),
        .hit      (cpu_hit),
        .act      (act)
    );

    wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (cpu_addr),
        .push_data (cpu_wdata),
        .pop       (q_pop),
        .head_addr (q_addr),
        .head_data (q_data),
        .empty     (q_empty),
        .full      (q_full)
    );

    wbuf_mem_port #(.AW(AW), .DW(DW)) u_mem_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (q_empty),
        .q_addr      (q_addr),
        .q_data      (q_data),
        .direct_req  (act == ACT_DIRECT),
        .direct_addr (cpu_addr),
        .direct_data (cpu_wdata),
        .mem_ready   (mem_ready),
        .mem_valid   (mem_valid),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .q_pop       (q_pop)
    );

    // Stall rule per action, acceptance and queue push.
    always_comb begin
        unique case (act)
            ACT_QUEUE:      cpu_stall = q_full;
            ACT_DIRECT:     cpu_stall = !(q_empty && mem_ready);
            ACT_READ_DRAIN: cpu_stall = !q_empty;
            default:        cpu_stall = 1'b0;
        endcase
        accept  = cpu_req && !cpu_stall;
        push    = accept && (act == ACT_QUEUE);
        fill_go = fill_req && q_empty;
    end

    // One-cycle dirty pulse after an absorbed write-back hit.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty_mark <= 1'b0;
        else        dirty_mark <= accept && (act == ACT_ABSORB);
    end

    a_r6_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && act == ACT_READ_DRAIN) |-> q_empty);
    a_r2_direct_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && act == ACT_DIRECT) |-> (mem_valid && mem_ready && q_empty));
    a_r7_fill_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |-> q_empty);
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_mark |=> (!dirty_mark || $past(accept)));
endmodule

// File: tb/test_wbuf_policy_top.sv
`timescale 1ns/1ps
module test_wbuf_policy_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 0, cpu_we = 0, cpu_swap = 0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_bufable = 0, cpu_cachable = 0, cpu_hit = 0;
    logic        cpu_stall, fill_req = 0, fill_go;
    logic        mem_valid, mem_ready = 0, dirty_mark;
    logic [31:0] mem_addr, mem_data;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    wbuf_policy_top i_wbuf_policy_top (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_swap(cpu_swap), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_bufable(cpu_bufable), .cpu_cachable(cpu_cachable),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .fill_req(fill_req),
        .fill_go(fill_go), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ready(mem_ready), .dirty_mark(dirty_mark)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Issue one access at a falling edge; wait until taken; count stalls.
    task automatic issue(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input logic b, input logic c, input logic h, input logic sw,
                         output int waits);
        int w = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cpu_bufable = b; cpu_cachable = c; cpu_hit = h; cpu_swap = sw;
        #5;
        while (cpu_stall && w < 100) begin
            @(negedge clk); #5; w++;
        end
        waits = w;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0; cpu_swap = 0;
    endtask

    // Expect the memory port to show a word, then let it go.
    task automatic pop_chk(input logic [31:0] a, input logic [31:0] d, input string tag);
        #5;
        chk(mem_valid, {tag, " mem_valid"}, 32'(mem_valid), 1);
        chk(mem_addr == a, {tag, " addr"}, mem_addr, a);
        chk(mem_data == d, {tag, " data"}, mem_data, d);
        mem_ready = 1;
        @(posedge clk);
        @(negedge clk);
        mem_ready = 0;
    endtask

    task automatic t_reset();
        @(negedge clk); #5;
        chk(!mem_valid, "R1 mem_valid", 32'(mem_valid), 0);
        chk(!cpu_stall, "R1 cpu_stall", 32'(cpu_stall), 0);
        chk(!dirty_mark, "R1 dirty_mark", 32'(dirty_mark), 0);
        fill_req = 1; #1;
        chk(fill_go, "R7 fill_go empty", 32'(fill_go), 1);
        fill_req = 0;
    endtask

    task automatic t_direct();
        @(negedge clk);
        mem_ready = 0;
        cpu_req = 1; cpu_we = 1; cpu_addr = 32'h100; cpu_wdata = 32'hAAAA5555;
        cpu_bufable = 0; cpu_cachable = 0; cpu_hit = 0;
        #5;
        chk(cpu_stall, "R2 stall", 32'(cpu_stall), 1);
        chk(mem_valid && mem_addr == 32'h100, "R2 addr", mem_addr, 32'h100);
        chk(mem_data == 32'hAAAA5555, "R2 data", mem_data, 32'hAAAA5555);
        repeat (3) @(negedge clk);
        #5;
        chk(cpu_stall, "R2 stall held", 32'(cpu_stall), 1);
        mem_ready = 1; #1;
        chk(!cpu_stall, "R2 stall drops", 32'(cpu_stall), 0);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0; mem_ready = 0; #5;
        chk(!mem_valid, "R2 done", 32'(mem_valid), 0);
    endtask

    task automatic t_queue_order();
        int w;
        mem_ready = 0;
        issue(1, 32'h200, 32'h11, 0, 1, 1, 0, w);
        chk(w == 0, "R3 wt hit no stall", w, 0);
        #5;
        chk(!dirty_mark, "R3 no dirty", 32'(dirty_mark), 0);
        chk(mem_valid && mem_addr == 32'h200, "R3 queued", mem_addr, 32'h200);
        @(negedge clk);
        issue(1, 32'h204, 32'h22, 0, 1, 0, 0, w);
        chk(w == 0, "R3 wt miss no stall", w, 0);
        issue(1, 32'h208, 32'h33, 1, 0, 0, 0, w);
        chk(w == 0, "R4 bufferable no stall", w, 0);
        repeat (2) @(negedge clk);
        #5;
        chk(mem_addr == 32'h200 && mem_data == 32'h11, "R9 stable head", mem_addr, 32'h200);
        @(negedge clk);
        pop_chk(32'h200, 32'h11, "R9 first");
        pop_chk(32'h204, 32'h22, "R9 second");
        pop_chk(32'h208, 32'h33, "R4 third");
        #5;
        chk(!mem_valid, "R9 drained", 32'(mem_valid), 0);
    endtask

    task automatic t_writeback();
        int w;
        mem_ready = 0;
        issue(1, 32'h300, 32'h44, 1, 1, 1, 0, w);
        #5;
        chk(dirty_mark, "R5 dirty pulse", 32'(dirty_mark), 1);
        chk(!mem_valid, "R5 hit not queued", 32'(mem_valid), 0);
        @(negedge clk); #5;
        chk(!dirty_mark, "R5 pulse one cycle", 32'(dirty_mark), 0);
        issue(1, 32'h304, 32'h55, 1, 1, 0, 0, w);
        #5;
        chk(!dirty_mark, "R5 miss no dirty", 32'(dirty_mark), 0);
        @(negedge clk);
        pop_chk(32'h304, 32'h55, "R5 miss queued");
    endtask

    task automatic t_swap();
        int w;
        mem_ready = 0;
        issue(1, 32'h400, 32'h66, 1, 0, 0, 0, w);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_swap = 1; cpu_addr = 32'h404; cpu_wdata = 32'h77;
        cpu_bufable = 1; cpu_cachable = 0; cpu_hit = 0;
        #5;
        chk(cpu_stall, "R4 swap waits", 32'(cpu_stall), 1);
        chk(mem_addr == 32'h400, "R4 queued first", mem_addr, 32'h400);
        mem_ready = 1; #1;
        chk(cpu_stall, "R4 swap stall while draining", 32'(cpu_stall), 1);
        @(posedge clk);
        @(negedge clk); #5;
        chk(!cpu_stall, "R4 swap taken", 32'(cpu_stall), 0);
        chk(mem_valid && mem_addr == 32'h404, "R4 swap direct", mem_addr, 32'h404);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0; cpu_swap = 0; mem_ready = 0; #5;
        chk(!mem_valid, "R4 swap not queued", 32'(mem_valid), 0);
    endtask

    task automatic t_read_fill();
        int w;
        mem_ready = 0;
        issue(1, 32'h500, 32'h88, 1, 0, 0, 0, w);
        fill_req = 1;
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_cachable = 1; cpu_bufable = 1; cpu_addr = 32'h600;
        #5;
        chk(!cpu_stall, "R6 cached read free", 32'(cpu_stall), 0);
        chk(!fill_go, "R7 fill held", 32'(fill_go), 0);
        @(posedge clk);
        @(negedge clk);
        cpu_cachable = 0; #5;
        chk(cpu_stall, "R6 uncached read waits", 32'(cpu_stall), 1);
        mem_ready = 1;
        @(posedge clk);
        @(negedge clk);
        mem_ready = 0; #5;
        chk(!cpu_stall, "R6 read after drain", 32'(cpu_stall), 0);
        chk(fill_go, "R7 fill after drain", 32'(fill_go), 1);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0; fill_req = 0;
    endtask

    task automatic t_full();
        int w;
        int stalled = 0;
        mem_ready = 0;
        for (int i = 0; i < 16; i++) begin
            issue(1, 32'h1000 + 32'(i) * 4, 32'(i + 1), 1, 0, 0, 0, w);
            if (w != 0) stalled++;
        end
        chk(stalled == 0, "R8 sixteen without stall", stalled, 0);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = 32'h2000; cpu_wdata = 32'h99;
        cpu_bufable = 1; cpu_cachable = 0; #5;
        chk(cpu_stall, "R8 full stalls", 32'(cpu_stall), 1);
        mem_ready = 1; #1;
        chk(mem_addr == 32'h1000, "R8 oldest at head", mem_addr, 32'h1000);
        @(posedge clk);
        @(negedge clk);
        mem_ready = 0; #5;
        chk(!cpu_stall, "R8 slot freed", 32'(cpu_stall), 0);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0;
        for (int i = 1; i < 16; i++)
            pop_chk(32'h1000 + 32'(i) * 4, 32'(i + 1), "R9 full order");
        pop_chk(32'h2000, 32'h99, "R8 last entry");
        #5;
        chk(!mem_valid, "R8 empty", 32'(mem_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_direct();
        t_queue_order();
        t_writeback();
        t_swap();
        t_read_fill();
        t_full();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            finish_run();
        end
    end
endmodule